// File: doc/BRIEF.md
# T1 Frame Timing and Strobe Generator

This block runs from the 1.544 MHz line clock and keeps track of where a T1 stream is: the bit within the frame, the channel, and the frame within the multiframe. From that position it derives the timing strobes that a serial framer needs. These are a channel clock marking the last bit of every channel and a per-channel gate selected by a mask. It also produces a sync pulse at frame or multiframe boundaries. A data-link clock and a link sample strobe qualify the framing-bit slots that carry link data.

The sync pin can run in two directions. As an output, the block free-runs and drives the pulse. As an input, a rising edge on the sync input realigns the counters to a boundary chosen by the host side. The multiframe is 12 frames long in D4 mode and 24 frames long in ESF mode. The link clock halves its rate when the ZBTSI option is set.

Top module: `t1_timing_gen`

## Requirements
- R1: A frame is 193 clocks. Position 0 is the framing-bit slot and positions 1 to 192 carry payload. When reset is released, the counters are at position 0 of frame 0, and the position then advances by one each clock.
- R2: `chan_clk` is high exactly at positions 8, 16, ..., 192, which are the least significant bits of the 24 channels. It is low everywhere else.
- R3: Channel c (0 to 23) occupies positions 8c+1 to 8c+8. During those positions `chan_blk` equals `chan_mask[c]`, so bit 0 of the mask belongs to the first channel. `chan_blk` is low in the framing-bit slot.
- R4: The frame index counts 0 to 11 when `esf_mode`=0 and 0 to 23 when `esf_mode`=1, then wraps to 0. With `mf_sync`=1 and sync as an output, `sync_out` is a single clock high at position 0 of frame 0.
- R5: With `mf_sync`=0 and sync as an output, `sync_out` is high at position 0 of every frame. When `dbl_wide`=1 it is also high at position 1 of the signaling frames, which are the frames whose index modulo 12 is 5 or 11.
- R6: `dbl_wide` has no effect when `mf_sync`=1 or `sync_in_mode`=1.
- R7: With `sync_in_mode`=1, `sync_out` and `sync_drive` are low. A clock edge that samples `sync_in` high, when it was low at the previous edge, sets the next position to 0. The frame index is also set to 0 if `mf_sync`=1 and left unchanged otherwise. With `sync_in_mode`=0, `sync_drive` is high and `sync_in` is ignored.
- R8: `link_strobe` is high only at position 0. Let p = (frame index − b) mod 4, where b is 0 in ESF mode and 1 in D4 mode. The strobe is high when p is even normally, and only when p = 0 with `zbtsi`=1.
- R9: `link_clk` equals bit 0 of p normally (a 4 kHz square wave) and bit 1 of p with `zbtsi`=1 (2 kHz). Its falling edge therefore comes at the start of the frame whose framing bit is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1.544 MHz line clock |
| rst | input | 1 | Synchronous active-high reset |
| esf_mode | input | 1 | 1 = 24-frame ESF multiframe, 0 = 12-frame D4 |
| mf_sync | input | 1 | Sync marks multiframes (1) or frames (0) |
| dbl_wide | input | 1 | Widen the frame sync pulse on signaling frames |
| sync_in_mode | input | 1 | 1 = sync pin is an input |
| zbtsi | input | 1 | Halve link clock and strobe rate |
| chan_mask | input | 24 | Per-channel block level, bit c = channel c |
| sync_in | input | 1 | External sync pulse |
| sync_out | output | 1 | Generated sync pulse |
| sync_drive | output | 1 | High when the sync pin should be driven |
| chan_clk | output | 1 | Channel LSB strobe |
| chan_blk | output | 1 | Per-channel block output |
| link_clk | output | 1 | Data-link demand clock |
| link_strobe | output | 1 | Link sample qualifier in framing-bit slots |

## Verification
The assertions assume that the mode inputs change only while reset is held. If they did not, a shorter multiframe could begin with the frame index already past its wrap point. The bench respects this by setting every configuration bit with reset asserted. It then sweeps all sixteen combinations of the four static mode bits across more than a full multiframe. External sync pulses of several clocks are applied at offsets unrelated to the frame length. These check that only the rising edge realigns the counters and that the same pulses are ignored when the pin is an output.

// File: rtl/t1tg_pkg.sv
package t1tg_pkg;

    // Static configuration of the timing generator.
    typedef struct packed {
        logic esf;
        logic mf_sync;
        logic dbl_wide;
        logic sync_in_mode;
        logic zbtsi;
    } tmode_t;

    // Direction of the sync pin.
    typedef enum logic {
        SYNC_ACCEPT = 1'b0,
        SYNC_DRIVE  = 1'b1
    } sync_dir_e;

    // A signaling frame is the middle or last frame of each group.
    function automatic logic is_sig_frame(input int unsigned frame,
                                          input int unsigned grp);
        int unsigned r;
        r = frame % grp;
        return (r == grp / 2 - 1) || (r == grp - 1);
    endfunction

endpackage

// File: rtl/t1tg_pos_counter.sv
module t1tg_pos_counter #(
    parameter int FRAME_LEN = 193,
    parameter int MF_SHORT  = 12,
    parameter int MF_LONG   = 24,
    parameter int BIT_W     = 8,
    parameter int FRM_W     = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             esf,
    input  logic             mf_sync,
    input  logic             load,
    output logic [BIT_W-1:0] bitpos,
    output logic [FRM_W-1:0] frame
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_LEN - 1);

    logic [FRM_W-1:0] last_frame;
    assign last_frame = esf ? FRM_W'(MF_LONG - 1) : FRM_W'(MF_SHORT - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            bitpos <= '0;
            frame  <= '0;
        end else if (load) begin
            bitpos <= '0;
            if (mf_sync)
                frame <= '0;
        end else if (bitpos == LAST_BIT) begin
            bitpos <= '0;
            frame  <= (frame >= last_frame) ? '0 : frame + FRM_W'(1);
        end else begin
            bitpos <= bitpos + BIT_W'(1);
        end
    end
endmodule

// File: rtl/t1tg_chan_strobe.sv
module t1tg_chan_strobe #(
    parameter int NUM_CH  = 24,
    parameter int CH_BITS = 8,
    parameter int BIT_W   = 8
) (
    input  logic [BIT_W-1:0]  bitpos,
    input  logic [NUM_CH-1:0] mask,
    output logic              chan_clk,
    output logic              chan_blk
);
    logic [NUM_CH-1:0] in_slot;
    logic [NUM_CH-1:0] at_lsb;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [BIT_W-1:0] LO = BIT_W'(c * CH_BITS + 1);
        localparam logic [BIT_W-1:0] HI = BIT_W'((c + 1) * CH_BITS);
        assign in_slot[c] = (bitpos >= LO) && (bitpos <= HI);
        assign at_lsb[c]  = (bitpos == HI);
    end

    assign chan_clk = |at_lsb;
    assign chan_blk = |(in_slot & mask);
endmodule

// File: rtl/t1tg_sync_link.sv
module t1tg_sync_link
    import t1tg_pkg::*;
#(
    parameter int SIG_GRP = 12,
    parameter int BIT_W   = 8,
    parameter int FRM_W   = 5
) (
    input  tmode_t           mode,
    input  logic [BIT_W-1:0] bitpos,
    input  logic [FRM_W-1:0] frame,
    output logic             sync_out,
    output logic             link_clk,
    output logic             link_strobe
);
    logic       f_start;
    logic       dbl_ok;
    logic       sig;
    logic [1:0] phase;

    assign f_start = (bitpos == '0);
    assign dbl_ok  = mode.dbl_wide && !mode.mf_sync && !mode.sync_in_mode;
    assign sig     = is_sig_frame(32'(frame), SIG_GRP);
    // Link phase: ESF link frames sit on even indices, D4 on odd ones.
    assign phase   = frame[1:0] - {1'b0, !mode.esf};

    always_comb begin
        if (mode.sync_in_mode)
            sync_out = 1'b0;
        else if (mode.mf_sync)
            sync_out = f_start && (frame == '0);
        else
            sync_out = f_start || (dbl_ok && sig && (bitpos == BIT_W'(1)));
    end

    assign link_strobe = f_start && (mode.zbtsi ? (phase == 2'd0) : !phase[0]);
    assign link_clk    = mode.zbtsi ? phase[1] : phase[0];
endmodule

// File: rtl/t1_timing_gen.sv
module t1_timing_gen
    import t1tg_pkg::*;
#(
    parameter int NUM_CH   = 24,
    parameter int CH_BITS  = 8,
    parameter int MF_SHORT = 12,
    parameter int MF_LONG  = 24,
    parameter int SIG_GRP  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              esf_mode,
    input  logic              mf_sync,
    input  logic              dbl_wide,
    input  logic              sync_in_mode,
    input  logic              zbtsi,
    input  logic [NUM_CH-1:0] chan_mask,
    input  logic              sync_in,
    output logic              sync_out,
    output logic              sync_drive,
    output logic              chan_clk,
    output logic              chan_blk,
    output logic              link_clk,
    output logic              link_strobe
);
    localparam int FRAME_LEN = NUM_CH * CH_BITS + 1;
    localparam int BIT_W     = $clog2(FRAME_LEN);
    localparam int FRM_W     = $clog2(MF_LONG);

    tmode_t           mode;
    sync_dir_e        dir;
    logic             sync_q;
    logic             load;
    logic [BIT_W-1:0] bitpos;
    logic [FRM_W-1:0] frame;

    assign mode = '{esf: esf_mode, mf_sync: mf_sync, dbl_wide: dbl_wide,
                    sync_in_mode: sync_in_mode, zbtsi: zbtsi};
    assign dir        = mode.sync_in_mode ? SYNC_ACCEPT : SYNC_DRIVE;
    assign sync_drive = (dir == SYNC_DRIVE);

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 1'b0;
        else     sync_q <= sync_in;
    end

    assign load = (dir == SYNC_ACCEPT) && sync_in && !sync_q;

    t1tg_pos_counter #(
        .FRAME_LEN(FRAME_LEN), .MF_SHORT(MF_SHORT), .MF_LONG(MF_LONG),
        .BIT_W(BIT_W), .FRM_W(FRM_W)
    ) u_pos (
        .clk(clk), .rst(rst), .esf(mode.esf), .mf_sync(mode.mf_sync),
        .load(load), .bitpos(bitpos), .frame(frame)
    );

    t1tg_chan_strobe #(
        .NUM_CH(NUM_CH), .CH_BITS(CH_BITS), .BIT_W(BIT_W)
    ) u_chan (
        .bitpos(bitpos), .mask(chan_mask),
        .chan_clk(chan_clk), .chan_blk(chan_blk)
    );

    t1tg_sync_link #(
        .SIG_GRP(SIG_GRP), .BIT_W(BIT_W), .FRM_W(FRM_W)
    ) u_sync (
        .mode(mode), .bitpos(bitpos), .frame(frame),
        .sync_out(sync_out), .link_clk(link_clk), .link_strobe(link_strobe)
    );
endmodule

// File: rtl/t1tg_checker.sv
module t1tg_checker #(
    parameter int FRAME_LEN = 193,
    parameter int MF_SHORT  = 12,
    parameter int MF_LONG   = 24,
    parameter int BIT_W     = 8,
    parameter int FRM_W     = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             esf_mode,
    input logic             mf_sync,
    input logic             dbl_wide,
    input logic             sync_in_mode,
    input logic             sync_in,
    input logic             sync_q,
    input logic [BIT_W-1:0] bitpos,
    input logic [FRM_W-1:0] frame,
    input logic             chan_clk,
    input logic             chan_blk,
    input logic             sync_out,
    input logic             link_strobe
);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_LEN - 1);

    logic             ext_edge;
    logic [FRM_W-1:0] last_frame;
    assign ext_edge   = sync_in_mode && sync_in && !sync_q;
    assign last_frame = esf_mode ? FRM_W'(MF_LONG - 1) : FRM_W'(MF_SHORT - 1);

    AST_BIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (bitpos != LAST_BIT && !ext_edge) |=> bitpos == $past(bitpos) + BIT_W'(1)); // R1
    AST_CHCLK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        chan_clk |=> !chan_clk); // R2
    AST_BLK_FBIT: assert property (@(posedge clk) disable iff (rst)
        (bitpos == '0) |-> !chan_blk); // R3
    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (rst)
        (bitpos == LAST_BIT && !ext_edge && frame == last_frame) |=> frame == '0); // R4
    AST_NARROW_SYNC: assert property (@(posedge clk) disable iff (rst)
        (sync_out && (mf_sync || !dbl_wide) && !ext_edge) |=> !sync_out); // R6
    AST_EXT_LOAD: assert property (@(posedge clk) disable iff (rst)
        ext_edge |=> bitpos == '0); // R7
    AST_IN_QUIET: assert property (@(posedge clk) disable iff (rst)
        sync_in_mode |-> !sync_out); // R7
    AST_STROBE_FBIT: assert property (@(posedge clk) disable iff (rst)
        link_strobe |-> bitpos == '0); // R8
endmodule

bind t1_timing_gen t1tg_checker #(
    .FRAME_LEN(FRAME_LEN), .MF_SHORT(MF_SHORT), .MF_LONG(MF_LONG),
    .BIT_W(BIT_W), .FRM_W(FRM_W)
) u_chk (
    .clk(clk), .rst(rst), .esf_mode(esf_mode), .mf_sync(mf_sync),
    .dbl_wide(dbl_wide), .sync_in_mode(sync_in_mode), .sync_in(sync_in),
    .sync_q(sync_q), .bitpos(bitpos), .frame(frame), .chan_clk(chan_clk),
    .chan_blk(chan_blk), .sync_out(sync_out), .link_strobe(link_strobe)
);

// File: tb/tb_t1_timing_gen.sv
module tb_t1_timing_gen;
    localparam int NCH  = 24;
    localparam int FLEN = 193;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic esf_mode = 1'b0, mf_sync = 1'b0, dbl_wide = 1'b0;
    logic sync_in_mode = 1'b0, zbtsi = 1'b0, sync_in = 1'b0;
    logic [NCH-1:0] chan_mask = '0;
    logic sync_out, sync_drive, chan_clk, chan_blk, link_clk, link_strobe;

    int n_chk = 0, n_bad = 0;
    int m_bit = 0, m_frm = 0, m_prev = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    t1_timing_gen dut (
        .clk(clk), .rst(rst), .esf_mode(esf_mode), .mf_sync(mf_sync),
        .dbl_wide(dbl_wide), .sync_in_mode(sync_in_mode), .zbtsi(zbtsi),
        .chan_mask(chan_mask), .sync_in(sync_in), .sync_out(sync_out),
        .sync_drive(sync_drive), .chan_clk(chan_clk), .chan_blk(chan_blk),
        .link_clk(link_clk), .link_strobe(link_strobe)
    );

    task automatic chk(input string tag, input string name,
                       input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at bit=%0d frame=%0d: actual=%b expected=%b",
                     tag, name, m_bit, m_frm, act, exp);
        end
    endtask

    // One clock: advance the bench's own position model, then compare.
    task automatic tick();
        int last, ph;
        bit ld, sig;
        logic e_sync, e_blk;
        string stag;
        @(negedge clk);
        last = esf_mode ? 23 : 11;
        if (rst) begin
            m_bit = 0; m_frm = 0; m_prev = 0;
        end else begin
            ld = sync_in_mode && sync_in && (m_prev == 0);
            if (ld) begin
                m_bit = 0;
                if (mf_sync) m_frm = 0;
            end else if (m_bit == FLEN - 1) begin
                m_bit = 0;
                m_frm = (m_frm >= last) ? 0 : m_frm + 1;
            end else begin
                m_bit++;
            end
            m_prev = sync_in;
        end
        // R2: channel LSB strobe; R1 frame length shows through its spacing
        chk("R1 R2", "chan_clk", chan_clk, (m_bit != 0) && (m_bit % 8 == 0));
        // R3: mask bit c gates positions 8c+1..8c+8
        e_blk = (m_bit == 0) ? 1'b0 : chan_mask[(m_bit - 1) / 8];
        chk("R3", "chan_blk", chan_blk, e_blk);
        // R7: pin direction
        chk("R7", "sync_drive", sync_drive, !sync_in_mode);
        sig = ((m_frm % 12) == 5) || ((m_frm % 12) == 11);
        if (sync_in_mode) begin
            e_sync = 1'b0; stag = dbl_wide ? "R6 R7" : "R7";
        end else if (mf_sync) begin
            e_sync = (m_bit == 0) && (m_frm == 0); stag = dbl_wide ? "R4 R6" : "R4";
        end else begin
            e_sync = (m_bit == 0) || (dbl_wide && sig && m_bit == 1); stag = "R1 R5";
        end
        chk(stag, "sync_out", sync_out, e_sync);
        ph = (m_frm - (esf_mode ? 0 : 1) + 4) % 4;
        chk("R8", "link_strobe", link_strobe,
            (m_bit == 0) && (zbtsi ? (ph == 0) : (ph % 2 == 0)));
        chk("R9", "link_clk", link_clk, zbtsi ? (ph >= 2) : (ph % 2 == 1));
    endtask

    task automatic start_cfg(input int cfg, input bit in_mode);
        rst = 1'b1;
        sync_in = 1'b0;
        esf_mode = cfg[0]; mf_sync = cfg[1]; dbl_wide = cfg[2]; zbtsi = cfg[3];
        sync_in_mode = in_mode;
        chan_mask = 24'h5A3C96 ^ {cfg[3:0], cfg[3:0], 16'h0F0F} ^ (24'h1 << cfg);
        repeat (3) tick();
        // R1: reset state is position 0 of frame 0
        chk("R1", "reset sync_out", sync_out, !in_mode);
        chk("R1", "reset chan_clk", chan_clk, 1'b0);
        rst = 1'b0;
    endtask

    initial begin
        // Output mode: all sixteen static mode combinations.
        for (int cfg = 0; cfg < 16; cfg++) begin
            start_cfg(cfg, 1'b0);
            for (int t = 0; t < (cfg[0] ? 24 : 12) * FLEN + 60; t++) begin
                // R7: pulses on sync_in are ignored while driving
                sync_in = (cfg[1] && (t % 517) < 3);
                tick();
            end
        end
        // Input mode: edges realign the counters; dbl_wide must not matter.
        for (int cfg = 0; cfg < 16; cfg++) begin
            start_cfg(cfg | 4, 1'b1);
            for (int t = 0; t < 1500; t++) begin
                sync_in = ((t % (331 + 17 * cfg)) >= 40) &&
                          ((t % (331 + 17 * cfg)) < 40 + (cfg % 4) + 1);
                tick();
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 190000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule